// File: doc/BRIEF.md
# Low-Power Mode Pin Controller

This block sequences the low-power modes of a small 8-bit microcontroller core. Control-register bits ask for Idle or Power Down. The block gates the core clock, the peripheral clocks and the oscillator to match. While a low-power mode is active, it overrides the two bus strobes (address latch enable and program-store enable) and the four 8-bit ports. Each pin is driven to a level, drives latched data or the last high address byte, or floats. The choice depends on the mode and on whether program memory is on chip or external.

The block also runs the exits, which differ between the two modes. Idle ends on an enabled interrupt at a machine-cycle boundary. Idle can also end by hardware reset, after a short drain window in which the core keeps running but RAM writes are blocked. Power Down ignores interrupts. Only a hardware reset ends it. That exit first re-enables the oscillator and holds the core in reset, RAM write-protected, for a programmable settling time.

The block refuses a Power Down request when the carry flag and bit 7 of the B register differ, and raises an error flag. The CPU core, the RAM array, the oscillator circuit and the special-function registers are outside the block. They are reached only through enable, inhibit and reset signals.

Top module: `lpm_ctrl`

## Requirements
- R1: In Idle (`mode_o`=1): `ale_o`=1, `psen_o`=1, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R2: In Power Down (`mode_o`=2): `ale_o`=0, `psen_o`=0, and `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R3: With `code_ext`=1, in Idle or Power Down, `p0_float`=1 and `p0_o`=0.
- R4: With `code_ext`=1, `p2_o` equals `addr_hi` in Idle and equals `p2_latch` in Power Down.
- R5: In Idle and Power Down, `pin_ovr`=1 and `p1_o`/`p3_o` follow their latches. With `code_ext`=0, `p0_o`/`p2_o` also follow their latches and `p0_float`=0. In every other mode, `pin_ovr`, the strobes, `p0_float` and all port outputs are 0.
- R6: Power Down is left only through `hw_rst`. An interrupt with a machine-cycle tick keeps `mode_o`=2.
- R7: `hw_rst` in Power Down moves to the settle state (`mode_o`=4). The settle state has `osc_en`=1, `core_rst`=1 and `ram_wr_inhibit`=1, and lasts max(`stab_cycles`,1) cycles. The block then enters reset hold (`mode_o`=5, `core_rst`=1, `ram_wr_inhibit`=1) until `hw_rst` is low, and then returns to Run (`mode_o`=0).
- R8: `hw_rst` in Idle moves to the drain state (`mode_o`=3). The drain state has `cpu_clk_en`=1, `ram_wr_inhibit`=1 and `core_rst`=0. It moves to reset hold on the second `mc_tick` seen in the drain state.
- R9: A Power Down request in Run with `carry_flag`≠`b_msb` leaves `mode_o`=0 and sets `pdown_err`. The flag stays set until the first clock edge at which `hw_rst` is high. With the two bits equal, the block enters Power Down.
- R10: In Idle, `irq_pend` with `mc_tick` raises `idle_clr` in that cycle, and the next edge returns to Run. `irq_pend` without `mc_tick` keeps Idle.
- R11: When both requests are high in Run, Power Down wins.
- R12: While `rst_n` is low, `mode_o`=0, `pdown_err`=0, all clock enables are 1 and `core_rst`=0.
- R13: In Run, `hw_rst` has priority over the mode requests and moves to reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| idle_req | input | 1 | Idle request bit |
| pdown_req | input | 1 | Power Down request bit |
| carry_flag | input | 1 | Core carry flag |
| b_msb | input | 1 | Bit 7 of the B register |
| irq_pend | input | 1 | An enabled interrupt is pending |
| mc_tick | input | 1 | Machine-cycle boundary strobe |
| hw_rst | input | 1 | Hardware reset pin, active high |
| code_ext | input | 1 | Program memory is external |
| stab_cycles | input | 8 | Oscillator settle length in cycles |
| addr_hi | input | 8 | Last high address byte |
| p0_latch | input | 8 | Port 0 data latch |
| p1_latch | input | 8 | Port 1 data latch |
| p2_latch | input | 8 | Port 2 data latch |
| p3_latch | input | 8 | Port 3 data latch |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| core_rst | output | 1 | Internal core reset |
| idle_clr | output | 1 | Clears the Idle request bit |
| pdown_err | output | 1 | Refused Power Down entry flag |
| pin_ovr | output | 1 | Pin overrides active |
| ale_o | output | 1 | Address latch enable level |
| psen_o | output | 1 | Program-store enable level |
| p0_float | output | 1 | Port 0 floats |
| p0_o | output | 8 | Port 0 drive value |
| p1_o | output | 8 | Port 1 drive value |
| p2_o | output | 8 | Port 2 drive value |
| p3_o | output | 8 | Port 3 drive value |

## Verification
The hardest situation to reach from the ports is the drain window after a reset ends Idle. The stimulus must first reach Idle with external code. It then raises `hw_rst` and spaces out `mc_tick` pulses, so that the bench sees the state hold through a tick-free cycle and through the first tick, and leave on the second tick. The Power Down exit is driven with a settle length of three and then of zero, which exercises both the counted path and the minimum one-cycle path. Wake tries in Power Down use an interrupt with a tick, to show that the tick is ignored there.

// File: rtl/lpm_pkg.sv
// Package: shared mode encoding and port geometry for the low-power controller.
// Assumes: mode codes are visible on mode_o and must keep these values.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_PDOWN = 3'd2,
        ST_DRAIN = 3'd3,
        ST_OSCW  = 3'd4,
        ST_RST   = 3'd5
    } lpm_state_e;

    localparam int NPORT = 4;
    localparam int PW    = 8;
endpackage

// File: rtl/lpm_count.sv
// Module: terminal counter used for both the drain window and the settle time.
// Counts inc pulses while clr is low; last is high when the current pulse
// would be the limit-th one (also high for a limit of zero).
// Assumes: the owner acts on last only together with inc.
module lpm_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Terminal compare, one bit wider so that cnt+1 cannot wrap.
    assign last = ({1'b0, cnt_q} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};

    // Pulse counter, cleared outside the owning state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpm_fsm.sv
// Module: mode sequencer. Holds the mode state, checks the Power Down entry
// condition, times the Idle drain window and the oscillator settle time, and
// decodes the clock, reset and RAM-inhibit controls.
// Assumes: mc_tick is a one-cycle strobe; requests are level bits from
// registers that the core clears (idle_clr, core_rst).
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int SW       = 8,
    parameter int DRAIN_MC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_req,
    input  logic          pdown_req,
    input  logic          carry_flag,
    input  logic          b_msb,
    input  logic          irq_pend,
    input  logic          mc_tick,
    input  logic          hw_rst,
    input  logic [SW-1:0] stab_cycles,
    output lpm_state_e    state,
    output logic          cpu_clk_en,
    output logic          periph_clk_en,
    output logic          osc_en,
    output logic          ram_wr_inhibit,
    output logic          core_rst,
    output logic          idle_clr,
    output logic          pdown_err
);
    localparam int DW = $clog2(DRAIN_MC + 1);
    localparam logic [DW-1:0] DRAIN_LIM = DW'(DRAIN_MC);

    lpm_state_e state_q, state_d;
    logic       err_q;
    logic       pd_ok;
    logic       drain_last;
    logic       stab_last;
    logic       wake;

    assign pd_ok = (carry_flag == b_msb);
    assign wake  = irq_pend && mc_tick;

    // Drain window: counts machine-cycle ticks after a reset ends Idle.
    lpm_count #(.W(DW)) u_drain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_DRAIN),
        .inc   (mc_tick),
        .limit (DRAIN_LIM),
        .last  (drain_last)
    );

    // Settle timer: counts clock cycles after the oscillator restarts.
    lpm_count #(.W(SW)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_OSCW),
        .inc   (1'b1),
        .limit (stab_cycles),
        .last  (stab_last)
    );

    // Next-state selection with reset, then Power Down, then Idle priority.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hw_rst)                  state_d = ST_RST;
                else if (pdown_req && pd_ok) state_d = ST_PDOWN;
                else if (pdown_req)          state_d = ST_RUN;
                else if (idle_req)           state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_rst)      state_d = ST_DRAIN;
                else if (wake)   state_d = ST_RUN;
            end
            ST_DRAIN: begin
                if (mc_tick && drain_last) state_d = ST_RST;
            end
            ST_PDOWN: begin
                if (hw_rst)      state_d = ST_OSCW;
            end
            ST_OSCW: begin
                if (stab_last)   state_d = ST_RST;
            end
            ST_RST: begin
                if (!hw_rst)     state_d = ST_RUN;
            end
            default:             state_d = ST_RUN;
        endcase
    end

    // Mode state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Sticky refused-entry flag, cleared by the hardware reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst) begin
            err_q <= 1'b0;
        end else if (state_q == ST_RUN && pdown_req && !pd_ok) begin
            err_q <= 1'b1;
        end
    end

    // Control decode from the current mode.
    always_comb begin
        cpu_clk_en     = !(state_q == ST_IDLE || state_q == ST_PDOWN);
        periph_clk_en  = (state_q != ST_PDOWN);
        osc_en         = (state_q != ST_PDOWN);
        ram_wr_inhibit = (state_q == ST_DRAIN) || (state_q == ST_OSCW) ||
                         (state_q == ST_RST);
        core_rst       = (state_q == ST_OSCW) || (state_q == ST_RST);
        idle_clr       = (state_q == ST_IDLE) && !hw_rst && wake;
    end

    assign state     = state_q;
    assign pdown_err = err_q;
endmodule

// File: rtl/lpm_pin_mux.sv
// Module: pin override decode. In the two low-power modes it sets the strobe
// levels and picks, per port, latched data, the high address byte or float.
// Assumes: outside the low-power modes the core owns the pins, so all
// override outputs are held at 0.
module lpm_pin_mux
    import lpm_pkg::*;
(
    input  lpm_state_e               state,
    input  logic                     code_ext,
    input  logic [NPORT-1:0][PW-1:0] port_latch,
    input  logic [PW-1:0]            addr_hi,
    output logic                     pin_ovr,
    output logic                     ale_o,
    output logic                     psen_o,
    output logic                     p0_float,
    output logic [NPORT-1:0][PW-1:0] port_o
);
    logic in_idle;
    logic in_pd;

    assign in_idle = (state == ST_IDLE);
    assign in_pd   = (state == ST_PDOWN);
    assign pin_ovr = in_idle || in_pd;

    // Strobes sit high in Idle and low in Power Down.
    always_comb begin
        ale_o  = in_idle;
        psen_o = in_idle;
    end

    // Per-port source selection.
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        if (i == 0) begin : g_mux_bus
            assign p0_float  = pin_ovr && code_ext;
            assign port_o[i] = (pin_ovr && !code_ext) ? port_latch[i] : '0;
        end else if (i == 2) begin : g_addr_bus
            assign port_o[i] = !pin_ovr               ? '0 :
                               (in_idle && code_ext)  ? addr_hi : port_latch[i];
        end else begin : g_plain
            assign port_o[i] = pin_ovr ? port_latch[i] : '0;
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
// Module: top of the low-power mode pin controller. Joins the sequencer and
// the pin override decode and presents flat ports.
// Assumes: clk keeps running in every mode (the oscillator it enables is
// outside; the block itself sits on an always-on clock).
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int SW       = 8,
    parameter int DRAIN_MC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_req,
    input  logic          pdown_req,
    input  logic          carry_flag,
    input  logic          b_msb,
    input  logic          irq_pend,
    input  logic          mc_tick,
    input  logic          hw_rst,
    input  logic          code_ext,
    input  logic [SW-1:0] stab_cycles,
    input  logic [7:0]    addr_hi,
    input  logic [7:0]    p0_latch,
    input  logic [7:0]    p1_latch,
    input  logic [7:0]    p2_latch,
    input  logic [7:0]    p3_latch,
    output logic [2:0]    mode_o,
    output logic          cpu_clk_en,
    output logic          periph_clk_en,
    output logic          osc_en,
    output logic          ram_wr_inhibit,
    output logic          core_rst,
    output logic          idle_clr,
    output logic          pdown_err,
    output logic          pin_ovr,
    output logic          ale_o,
    output logic          psen_o,
    output logic          p0_float,
    output logic [7:0]    p0_o,
    output logic [7:0]    p1_o,
    output logic [7:0]    p2_o,
    output logic [7:0]    p3_o
);
    lpm_state_e               state;
    logic [NPORT-1:0][PW-1:0] latch_bus;
    logic [NPORT-1:0][PW-1:0] port_bus;

    assign latch_bus = {p3_latch, p2_latch, p1_latch, p0_latch};

    // Mode sequencer.
    lpm_fsm #(.SW(SW), .DRAIN_MC(DRAIN_MC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .idle_req       (idle_req),
        .pdown_req      (pdown_req),
        .carry_flag     (carry_flag),
        .b_msb          (b_msb),
        .irq_pend       (irq_pend),
        .mc_tick        (mc_tick),
        .hw_rst         (hw_rst),
        .stab_cycles    (stab_cycles),
        .state          (state),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .osc_en         (osc_en),
        .ram_wr_inhibit (ram_wr_inhibit),
        .core_rst       (core_rst),
        .idle_clr       (idle_clr),
        .pdown_err      (pdown_err)
    );

    // Pin override decode.
    lpm_pin_mux u_pins (
        .state      (state),
        .code_ext   (code_ext),
        .port_latch (latch_bus),
        .addr_hi    (addr_hi),
        .pin_ovr    (pin_ovr),
        .ale_o      (ale_o),
        .psen_o     (psen_o),
        .p0_float   (p0_float),
        .port_o     (port_bus)
    );

    assign mode_o = state;
    assign p0_o   = port_bus[0];
    assign p1_o   = port_bus[1];
    assign p2_o   = port_bus[2];
    assign p3_o   = port_bus[3];
endmodule

// File: rtl/lpm_ctrl_chk.sv
// Module: property checker for lpm_ctrl, attached by bind.
// Assumes: mode codes of lpm_pkg.
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       carry_flag,
    input logic       b_msb,
    input logic       irq_pend,
    input logic       mc_tick,
    input logic       hw_rst,
    input logic       code_ext,
    input logic [2:0] mode_o,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       ram_wr_inhibit,
    input logic       core_rst,
    input logic       pin_ovr,
    input logic       ale_o,
    input logic       psen_o,
    input logic       p0_float,
    input logic [7:0] p0_o
);
    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (ale_o && psen_o && !cpu_clk_en && osc_en)); // R1

    AST_PD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2) |-> (!ale_o && !psen_o && !osc_en)); // R2

    AST_P0_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ovr && code_ext) |-> (p0_float && p0_o == 8'h00)); // R3

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && !hw_rst) |=> (mode_o == 3'd2)); // R6

    AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |=> (mode_o == 3'd4 || (mode_o == 3'd5 && core_rst))); // R7

    AST_DRAIN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> (ram_wr_inhibit && cpu_clk_en && !core_rst)); // R8

    AST_PD_ENTRY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !hw_rst) |=> (mode_o != 3'd2 || $past(carry_flag == b_msb))); // R9

    AST_WAKE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && !hw_rst && !(irq_pend && mc_tick)) |=> (mode_o == 3'd1)); // R10
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
    localparam logic [2:0] M_RUN = 3'd0, M_IDLE = 3'd1, M_PD = 3'd2,
                           M_DRAIN = 3'd3, M_OSCW = 3'd4, M_RST = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n, idle_req, pdown_req, carry_flag, b_msb, irq_pend, mc_tick;
    logic       hw_rst, code_ext;
    logic [7:0] stab_cycles, addr_hi, p0_latch, p1_latch, p2_latch, p3_latch;
    logic [2:0] mode_o;
    logic       cpu_clk_en, periph_clk_en, osc_en, ram_wr_inhibit, core_rst;
    logic       idle_clr, pdown_err, pin_ovr, ale_o, psen_o, p0_float;
    logic [7:0] p0_o, p1_o, p2_o, p3_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic exp_err = 1'b0;

    typedef struct {
        string       tag;
        logic [44:0] vec;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    lpm_ctrl u0 (.*);

    // Expected output vector for a mode, from the requirements.
    function automatic logic [44:0] exp_vec(logic [2:0] m, logic err);
        logic idl, pd, ovr;
        logic [7:0] e0, e2;
        idl = (m == M_IDLE);
        pd  = (m == M_PD);
        ovr = idl || pd;
        e0  = (ovr && !code_ext) ? p0_latch : 8'h00;
        e2  = !ovr ? 8'h00 : ((idl && code_ext) ? addr_hi : p2_latch);
        return {m, !ovr, !pd, !pd,
                (m == M_DRAIN || m == M_OSCW || m == M_RST),
                (m == M_OSCW || m == M_RST), err, ovr, idl, idl,
                ovr && code_ext, e0, ovr ? p1_latch : 8'h00, e2,
                ovr ? p3_latch : 8'h00};
    endfunction

    function automatic logic [44:0] obs_vec();
        return {mode_o, cpu_clk_en, periph_clk_en, osc_en, ram_wr_inhibit,
                core_rst, pdown_err, pin_ovr, ale_o, psen_o, p0_float,
                p0_o, p1_o, p2_o, p3_o};
    endfunction

    // Driver: one clock edge, then queue the outputs expected after it.
    task automatic step(string tag, logic [2:0] m);
        @(posedge clk);
        sb_q.push_back('{tag: tag, vec: exp_vec(m, exp_err)});
        @(negedge clk);
    endtask

    task automatic direct(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: compares queued expectations just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (obs_vec() !== it.vec) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, obs_vec(), it.vec);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_req = 0; pdown_req = 0; carry_flag = 0; b_msb = 0;
        irq_pend = 0; mc_tick = 0; hw_rst = 0; code_ext = 0; stab_cycles = 8'd3;
        addr_hi = 8'hA5; p0_latch = 8'h11; p1_latch = 8'h22; p2_latch = 8'h33;
        p3_latch = 8'h44;
        repeat (3) @(negedge clk);
        idle_req = 1; pdown_req = 1;
        step("R12 reset state", M_RUN);
        idle_req = 0; pdown_req = 0; rst_n = 1;

        // Idle with internal code, interrupt wake.
        idle_req = 1;
        step("R1 R5 idle internal code", M_IDLE);
        irq_pend = 1;
        step("R10 irq without tick stays idle", M_IDLE);
        mc_tick = 1;
        #1 direct("R10 idle_clr on wake", idle_clr, 1'b1);
        step("R10 wake to run", M_RUN);
        idle_req = 0; irq_pend = 0; mc_tick = 0;
        step("R5 run releases pins", M_RUN);

        // Idle with external code, reset through the drain window.
        code_ext = 1; addr_hi = 8'h5C; p2_latch = 8'h9E;
        idle_req = 1;
        step("R3 R4 idle external code", M_IDLE);
        idle_req = 0; hw_rst = 1;
        step("R8 drain entry", M_DRAIN);
        step("R8 drain without tick", M_DRAIN);
        mc_tick = 1;
        step("R8 drain first tick", M_DRAIN);
        step("R8 drain second tick", M_RST);
        mc_tick = 0;
        step("R7 reset hold", M_RST);
        hw_rst = 0;
        step("R7 reset release", M_RUN);

        // Valid Power Down with external code, settle of three cycles.
        carry_flag = 1; b_msb = 1; pdown_req = 1;
        step("R2 R4 R9 power down entry", M_PD);
        pdown_req = 0; irq_pend = 1; mc_tick = 1;
        step("R6 irq ignored in power down", M_PD);
        irq_pend = 0; mc_tick = 0; stab_cycles = 8'd3; hw_rst = 1;
        step("R7 settle 1", M_OSCW);
        step("R7 settle 2", M_OSCW);
        step("R7 settle 3", M_OSCW);
        step("R7 settle done", M_RST);
        hw_rst = 0;
        step("R7 back to run", M_RUN);

        // Refused Power Down entry.
        b_msb = 0; pdown_req = 1;
        exp_err = 1'b1;
        step("R9 refused entry", M_RUN);
        pdown_req = 0;
        step("R9 error sticky", M_RUN);
        hw_rst = 1;
        exp_err = 1'b0;
        step("R9 R13 error cleared by reset", M_RST);
        hw_rst = 0;
        step("R13 release", M_RUN);

        // Both requests, internal code, zero settle length.
        code_ext = 0; carry_flag = 0; b_msb = 0; idle_req = 1; pdown_req = 1;
        step("R11 R5 power down wins", M_PD);
        idle_req = 0; pdown_req = 0; stab_cycles = 8'd0; hw_rst = 1;
        step("R7 zero settle", M_OSCW);
        step("R7 zero settle done", M_RST);
        hw_rst = 0;
        step("R7 run after zero settle", M_RUN);

        // Reset beats a request in Run.
        idle_req = 1; hw_rst = 1;
        step("R13 reset priority", M_RST);
        idle_req = 0; hw_rst = 0;
        step("R13 run again", M_RUN);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule